// File: doc/BRIEF.md
# Strobe-Addressed Control and Status Register

This block is a 16-bit control and status word that sits on a simple system-board slave bus. Software changes a control bit by writing to that bit's own set address or clear address. The written data value plays no part. One read at the base address returns every bit at once as a halfword.

Some bits capture hardware events and stay set until software clears them: bus timeout, parity error and alignment trap. A DMA end-of-process is also captured, but only when the transfer belongs to one of the two UART channels. A second group of bits tracks interrupt levels from devices, one cycle late: floppy, clock, UART and I/O fault.

The block drives the LED, the floppy motor, two inhibit controls and two programmed-interrupt requests. It also produces a one-cycle reset-request pulse.

Top module: `ctl_status_latch`

## Requirements
- R1: After reset every bit of the status word reads 0, every control output is low and `rst_req_pulse` is low.
- R2: A write to `BASE + 3 + 4*n` (n = 0..15) performs action n, whatever the value on `bus_wdata`. The actions in order of n are:
  - 0: clear timeout (bit 15)
  - 1: clear parity (bit 14)
  - 2: set reset request (bit 13)
  - 3: clear alignment (bit 12)
  - 4: LED on (bit 11)
  - 5: LED off (bit 11)
  - 6: motor on (bit 10)
  - 7: motor off (bit 10)
  - 8: timer inhibit set (bit 8)
  - 9: timer inhibit clear (bit 8)
  - 10: fault inhibit set (bit 7)
  - 11: fault inhibit clear (bit 7)
  - 12: PIR9 set (bit 4)
  - 13: PIR9 clear (bit 4)
  - 14: PIR8 set (bit 5)
  - 15: PIR8 clear (bit 5)
- R3: A write to any other address, including the unmapped offsets 0x00..0x3F of the window, leaves the status word unchanged. A read at any address other than `BASE` returns 0.
- R4: A read at `BASE` returns the status word in the same cycle, with bits placed as listed in R2, R7, R8 and R9. Bit 9 always reads 0.
- R5: `led_on`, `motor_on`, `timer_inhibit` and `fault_inhibit` always equal status bits 11, 10, 8 and 7.
- R6: PIR8 (bit 5, output `pir8_req`) and PIR9 (bit 4, output `pir9_req`) stay set until their own clear strobe is written. Nothing else changes them.
- R7: A one-cycle pulse on `bus_timeout`, `parity_err` or `align_trap` sets bit 15, 14 or 12, and the bit stays set until its clear strobe. When the event and the clear strobe occur in the same cycle, the bit ends set.
- R8: A `dma_eop` pulse sets bit 1 only when `dma_chan` equals `UART_CH_A` (2) or `UART_CH_B` (3). A read at `BASE` clears bit 1 after returning it, and a qualifying pulse in the same cycle as that read leaves bit 1 set.
- R9: Bits 2, 6, 3 and 0 show the level that `floppy_irq`, `clock_irq`, `uart_irq` and `io_fault` had one clock earlier.
- R10: The reset-request strobe sets bit 13, which then stays set until reset. In the cycle after the strobe, `rst_req_pulse` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (20) | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data (ignored) |
| bus_rdata | output | 16 | Read data |
| bus_timeout | input | 1 | Bus timeout event pulse |
| parity_err | input | 1 | Parity error event pulse |
| align_trap | input | 1 | Alignment trap event pulse |
| dma_eop | input | 1 | DMA end-of-process pulse |
| dma_chan | input | CH_W (2) | Channel of the ending DMA transfer |
| floppy_irq | input | 1 | Floppy controller interrupt level |
| clock_irq | input | 1 | Clock interrupt level |
| uart_irq | input | 1 | UART interrupt level |
| io_fault | input | 1 | I/O fault level |
| led_on | output | 1 | LED drive |
| motor_on | output | 1 | Floppy motor enable |
| timer_inhibit | output | 1 | Timer inhibit control |
| fault_inhibit | output | 1 | Fault inhibit control |
| pir8_req | output | 1 | Programmed interrupt 8 request |
| pir9_req | output | 1 | Programmed interrupt 9 request |
| rst_req_pulse | output | 1 | One-cycle reset request pulse |

## Verification
The bench writes every strobe address in turn with changing data, and it writes every unmapped offset of the window. A decoder that swapped two strobes, or that looked at the data, would flip the wrong bit. A decoder that ignored the low address bits would react to an unmapped offset.

The bench makes an event and its clear strobe collide in the same cycle, and makes a DMA end-of-process collide with a clearing read. A clear-wins priority would lose the event.

End-of-process is sent on all four channels. A missing channel qualifier would latch the DMA bit for the non-UART channels.

The bench also checks that the reset-request pulse lasts a single cycle, and that the level bits lag their inputs by exactly one cycle.

// File: rtl/ctl_status_pkg.sv
package ctl_status_pkg;
   localparam int WORD_W = 16;
   localparam int N_STB  = 16;

   localparam int B_TMO  = 15;
   localparam int B_PAR  = 14;
   localparam int B_RRQ  = 13;
   localparam int B_ALN  = 12;
   localparam int B_LED  = 11;
   localparam int B_MOT  = 10;
   localparam int B_NONE = 9;
   localparam int B_TINH = 8;
   localparam int B_FINH = 7;
   localparam int B_CLK  = 6;
   localparam int B_PIR8 = 5;
   localparam int B_PIR9 = 4;
   localparam int B_UART = 3;
   localparam int B_DISK = 2;
   localparam int B_DMA  = 1;
   localparam int B_IOF  = 0;

   // bits held by a set/clear latch
   localparam logic [WORD_W-1:0] LATCH_MASK = 16'b1111_1101_1011_0010;
   // bits that follow an input level
   localparam logic [WORD_W-1:0] LEVEL_MASK = 16'b0000_0000_0100_1101;

   typedef enum logic [3:0] {
      S_CLR_TMO, S_CLR_PAR, S_REQ_RST, S_CLR_ALN,
      S_LED_ON,  S_LED_OFF, S_MOT_ON,  S_MOT_OFF,
      S_TINH_SET, S_TINH_CLR, S_FINH_SET, S_FINH_CLR,
      S_PIR9_SET, S_PIR9_CLR, S_PIR8_SET, S_PIR8_CLR
   } strobe_e;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
   parameter int ADDR_W = 20,
   parameter logic [ADDR_W-1:0] BASE = 20'h44000,
   parameter int N_STROBE = 16,
   parameter int FIRST_OFS = 3,
   parameter int STRIDE = 4
) (
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   output logic [N_STROBE-1:0] strobe_o,
   output logic                read_hit_o
);
   localparam int SPAN = FIRST_OFS + STRIDE * (N_STROBE - 1);

   if (SPAN >= (1 << (ADDR_W - 1))) begin : g_bad_span
      $error("strobe span does not fit the address width");
   end
   if (STRIDE <= FIRST_OFS) begin : g_bad_stride
      $error("stride must exceed the first offset so that the read address stays free");
   end

   for (genvar g = 0; g < N_STROBE; g++) begin : g_stb
      localparam logic [ADDR_W-1:0] STB_ADDR = BASE + ADDR_W'(FIRST_OFS + STRIDE * g);
      assign strobe_o[g] = bus_wr && (bus_addr == STB_ADDR);
   end

   assign read_hit_o = bus_rd && (bus_addr == BASE);
endmodule

// File: rtl/csr_latch_bit.sv
module csr_latch_bit #(
   parameter bit SET_PRIO = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_nx;

   if (SET_PRIO) begin : g_set_first
      always_comb begin
         if (set_i)      q_nx = 1'b1;
         else if (clr_i) q_nx = 1'b0;
         else            q_nx = q_o;
      end
   end else begin : g_clr_first
      always_comb begin
         if (clr_i)      q_nx = 1'b0;
         else if (set_i) q_nx = 1'b1;
         else            q_nx = q_o;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_nx;
   end

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_PRIO && set_i) |=> q_o);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/csr_level_track.sv
module csr_level_track #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("at least one stage is required");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, d_i};
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ctl_status_latch.sv
module ctl_status_latch
   import ctl_status_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter logic [ADDR_W-1:0] BASE = 20'h44000,
   parameter int CH_W = 2,
   parameter int UART_CH_A = 2,
   parameter int UART_CH_B = 3,
   parameter int LEVEL_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              bus_timeout,
   input  logic              parity_err,
   input  logic              align_trap,
   input  logic              dma_eop,
   input  logic [CH_W-1:0]   dma_chan,
   input  logic              floppy_irq,
   input  logic              clock_irq,
   input  logic              uart_irq,
   input  logic              io_fault,
   output logic              led_on,
   output logic              motor_on,
   output logic              timer_inhibit,
   output logic              fault_inhibit,
   output logic              pir8_req,
   output logic              pir9_req,
   output logic              rst_req_pulse
);
   if (UART_CH_A >= (1 << CH_W) || UART_CH_B >= (1 << CH_W)) begin : g_bad_ch
      $error("UART channel numbers do not fit the channel width");
   end
   if ((LATCH_MASK & LEVEL_MASK) != '0) begin : g_bad_mask
      $error("a bit cannot be both latched and level-tracked");
   end

   logic [N_STB-1:0]  stb;
   logic              read_hit;
   logic [WORD_W-1:0] set_v, clr_v, word;
   logic              dma_qual;
   logic              bus_wdata_unused;

   assign bus_wdata_unused = ^bus_wdata;

   csr_addr_decode #(
      .ADDR_W(ADDR_W), .BASE(BASE), .N_STROBE(N_STB), .FIRST_OFS(3), .STRIDE(4)
   ) u_dec (
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .strobe_o(stb), .read_hit_o(read_hit)
   );

   assign dma_qual = dma_eop &&
      ((dma_chan == CH_W'(UART_CH_A)) || (dma_chan == CH_W'(UART_CH_B)));

   always_comb begin
      set_v = '0;
      clr_v = '0;
      set_v[B_TMO]  = bus_timeout;          clr_v[B_TMO]  = stb[int'(S_CLR_TMO)];
      set_v[B_PAR]  = parity_err;           clr_v[B_PAR]  = stb[int'(S_CLR_PAR)];
      set_v[B_RRQ]  = stb[int'(S_REQ_RST)];
      set_v[B_ALN]  = align_trap;           clr_v[B_ALN]  = stb[int'(S_CLR_ALN)];
      set_v[B_LED]  = stb[int'(S_LED_ON)];  clr_v[B_LED]  = stb[int'(S_LED_OFF)];
      set_v[B_MOT]  = stb[int'(S_MOT_ON)];  clr_v[B_MOT]  = stb[int'(S_MOT_OFF)];
      set_v[B_TINH] = stb[int'(S_TINH_SET)]; clr_v[B_TINH] = stb[int'(S_TINH_CLR)];
      set_v[B_FINH] = stb[int'(S_FINH_SET)]; clr_v[B_FINH] = stb[int'(S_FINH_CLR)];
      set_v[B_PIR8] = stb[int'(S_PIR8_SET)]; clr_v[B_PIR8] = stb[int'(S_PIR8_CLR)];
      set_v[B_PIR9] = stb[int'(S_PIR9_SET)]; clr_v[B_PIR9] = stb[int'(S_PIR9_CLR)];
      set_v[B_DMA]  = dma_qual;             clr_v[B_DMA]  = read_hit;
      set_v[B_CLK]  = clock_irq;
      set_v[B_UART] = uart_irq;
      set_v[B_DISK] = floppy_irq;
      set_v[B_IOF]  = io_fault;
   end

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (LATCH_MASK[i]) begin : g_latch
         csr_latch_bit #(.SET_PRIO(1'b1)) u_bit (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(word[i])
         );
      end else if (LEVEL_MASK[i]) begin : g_level
         logic clr_unused;
         assign clr_unused = clr_v[i];
         csr_level_track #(.STAGES(LEVEL_STAGES)) u_lvl (
            .clk(clk), .rst_n(rst_n), .d_i(set_v[i]), .q_o(word[i])
         );
      end else begin : g_zero
         logic sc_unused;
         assign sc_unused = set_v[i] ^ clr_v[i];
         assign word[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rst_req_pulse <= 1'b0;
      else        rst_req_pulse <= stb[int'(S_REQ_RST)];
   end

   assign bus_rdata     = read_hit ? word : '0;
   assign led_on        = word[B_LED];
   assign motor_on      = word[B_MOT];
   assign timer_inhibit = word[B_TINH];
   assign fault_inhibit = word[B_FINH];
   assign pir8_req      = word[B_PIR8];
   assign pir9_req      = word[B_PIR9];

   // R8
   dma_other_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_eop && dma_chan != CH_W'(UART_CH_A) && dma_chan != CH_W'(UART_CH_B) && !word[B_DMA])
      |=> !word[B_DMA]);

   // R6
   pir8_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pir8_req && !stb[int'(S_PIR8_CLR)]) |=> pir8_req);

   // R10
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_pulse |-> word[B_RRQ]);

   // R10
   rrq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word[B_RRQ] |=> word[B_RRQ]);

   // R7
   align_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb[int'(S_CLR_ALN)] && !align_trap) |=> !word[B_ALN]);

   // R3
   miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != BASE) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_ctl_status_latch.sv
module sim_ctl_status_latch;
   localparam logic [19:0] BASE = 20'h44000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic        bus_timeout = 0, parity_err = 0, align_trap = 0, dma_eop = 0;
   logic [1:0]  dma_chan = '0;
   logic        floppy_irq = 0, clock_irq = 0, uart_irq = 0, io_fault = 0;
   logic        led_on, motor_on, timer_inhibit, fault_inhibit, pir8_req, pir9_req, rst_req_pulse;

   int checks = 0, errors = 0;
   logic [15:0] exp_w = '0;
   logic [15:0] got;

   always #5 clk = ~clk;

   ctl_status_latch u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_timeout(bus_timeout),
      .parity_err(parity_err), .align_trap(align_trap), .dma_eop(dma_eop),
      .dma_chan(dma_chan), .floppy_irq(floppy_irq), .clock_irq(clock_irq),
      .uart_irq(uart_irq), .io_fault(io_fault), .led_on(led_on), .motor_on(motor_on),
      .timer_inhibit(timer_inhibit), .fault_inhibit(fault_inhibit),
      .pir8_req(pir8_req), .pir9_req(pir9_req), .rst_req_pulse(rst_req_pulse)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic [15:0] model_strobe(logic [15:0] w, int n);
      logic [15:0] r = w;
      case (n)
         0: r[15] = 0;   1: r[14] = 0;   2: r[13] = 1;   3: r[12] = 0;
         4: r[11] = 1;   5: r[11] = 0;   6: r[10] = 1;   7: r[10] = 0;
         8: r[8] = 1;    9: r[8] = 0;    10: r[7] = 1;   11: r[7] = 0;
         12: r[4] = 1;   13: r[4] = 0;   14: r[5] = 1;   15: r[5] = 0;
         default: ;
      endcase
      return r;
   endfunction

   task automatic wr(logic [19:0] a, logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(logic [19:0] a, output logic [15:0] v);
      bus_addr = a; bus_rd = 1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic chk_word(string req);
      logic [15:0] v;
      rd(BASE, v);
      check(req, v, exp_w);
      exp_w[1] = 1'b0;
   endtask

   task automatic chk_outs(string req);
      check(req, {10'b0, led_on, motor_on, timer_inhibit, fault_inhibit, pir8_req, pir9_req},
            {10'b0, exp_w[11], exp_w[10], exp_w[8], exp_w[7], exp_w[5], exp_w[4]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk_word("R1");
      chk_outs("R1");
      check("R1 pulse", {15'b0, rst_req_pulse}, 16'h0);

      // R2 R4 R5 R6: sweep every strobe twice with varying data
      for (int pass = 0; pass < 2; pass++) begin
         for (int n = 0; n < 16; n++) begin
            if (n == 2) continue;
            wr(BASE + 20'(3 + 4 * n), 16'(n * 16'h1111 ^ pass * 16'hffff));
            exp_w = model_strobe(exp_w, n);
            chk_word("R2");
            chk_outs("R5");
         end
         for (int n = 15; n >= 0; n--) begin
            if (n == 2) continue;
            if (n % 2 == 1) continue;
            wr(BASE + 20'(3 + 4 * n), 16'hffff);
            exp_w = model_strobe(exp_w, n);
         end
         chk_word("R4");
         chk_outs("R6");
      end

      // R6 PIR bits hold while other strobes are written
      for (int n = 4; n < 12; n++) begin
         wr(BASE + 20'(3 + 4 * n), 16'h0);
         exp_w = model_strobe(exp_w, n);
      end
      chk_word("R6 hold");

      // R3 unmapped offsets and outside writes
      for (int o = 0; o < 64; o++) begin
         if (o % 4 == 3) continue;
         wr(BASE + 20'(o), 16'hffff);
      end
      wr(BASE + 20'h43, 16'hffff);
      wr(20'h45003, 16'hffff);
      chk_word("R3 write");
      rd(BASE + 20'h4, got);
      check("R3 read", got, 16'h0);
      rd(BASE + 20'h3, got);
      check("R3 read", got, 16'h0);

      // R7 sticky events and clears
      bus_timeout = 1; parity_err = 1; align_trap = 1;
      @(negedge clk);
      bus_timeout = 0; parity_err = 0; align_trap = 0;
      exp_w[15] = 1; exp_w[14] = 1; exp_w[12] = 1;
      repeat (3) @(negedge clk);
      chk_word("R7 set");
      wr(BASE + 20'h07, 16'h0); exp_w[14] = 0;
      chk_word("R7 clear");
      // set wins over clear
      bus_timeout = 1;
      wr(BASE + 20'h03, 16'h0);
      bus_timeout = 0;
      chk_word("R7 set wins");
      align_trap = 1;
      wr(BASE + 20'h0f, 16'h0);
      align_trap = 0;
      chk_word("R7 set wins");
      wr(BASE + 20'h03, 16'h0); exp_w[15] = 0;
      wr(BASE + 20'h0f, 16'h0); exp_w[12] = 0;
      chk_word("R7 clear");

      // R8 DMA qualification per channel
      for (int c = 0; c < 4; c++) begin
         dma_chan = 2'(c); dma_eop = 1;
         @(negedge clk);
         dma_eop = 0;
         if (c >= 2) exp_w[1] = 1;
         chk_word("R8 chan");
         chk_word("R8 read clears");
      end
      // qualifying eop during clearing read
      dma_chan = 2'd3; dma_eop = 1;
      rd(BASE, got);
      dma_eop = 0;
      check("R8 same-cycle old", got, exp_w);
      exp_w[1] = 1;
      chk_word("R8 set wins");

      // R9 level bits lag by one cycle
      for (int p = 0; p < 16; p++) begin
         {floppy_irq, clock_irq, uart_irq, io_fault} = 4'(p);
         @(negedge clk);
         exp_w[2] = p[3]; exp_w[6] = p[2]; exp_w[3] = p[1]; exp_w[0] = p[0];
         rd(BASE, got);
         check("R9", got, exp_w);
      end
      {floppy_irq, clock_irq, uart_irq, io_fault} = 4'b0;
      @(negedge clk);
      rd(BASE, got);
      exp_w[2] = 0; exp_w[6] = 0; exp_w[3] = 0; exp_w[0] = 0;
      check("R9 lag", got, exp_w);

      // R10 reset request pulse
      wr(BASE + 20'h0b, 16'h1234);
      exp_w[13] = 1;
      check("R10 pulse high", {15'b0, rst_req_pulse}, 16'h1);
      @(negedge clk);
      check("R10 pulse one cycle", {15'b0, rst_req_pulse}, 16'h0);
      for (int n = 0; n < 16; n++) begin
         if (n == 2) continue;
         wr(BASE + 20'(3 + 4 * n), 16'h0);
         exp_w = model_strobe(exp_w, n);
      end
      chk_word("R10 sticky");

      // R1 reset again clears everything
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      exp_w = '0;
      chk_word("R1 reset");
      chk_outs("R1 reset");

      finish_run();
   end
endmodule